// File: doc/BRIEF.md
# Refresh Interval Timer with Keyed Register Writes

This block paces memory refresh. An 8-bit up-counter advances on a tick taken from a free-running prescaler, and a 3-bit clock-select field picks which tick to use. When a tick arrives while the counter equals the programmed compare constant, the counter returns to zero and a compare-match flag is set. If the externally supplied refresh enable is high at that moment, the block also emits a one-cycle CAS-before-RAS refresh request. The interrupt output is a level equal to the flag ANDed with an interrupt-enable bit. A memory bus sequencer outside the block consumes the request and performs the refresh.

Software reaches the timer through a 16-bit register port. The control/status register and the compare constant accept data only from a full-word write whose upper byte carries a key. Each register has its own key, and any other write to them is dropped. The counter can be read at its own address but cannot be written. There are two resets. Power-on reset initialises everything, including the constant, which goes to 0x00FF. Manual reset clears the counter, the control/status register and the prescaler, but the constant keeps its value.

Top module: `rfsh_tmr`

## Requirements
- R1: After power-on reset, the control/status word reads 0x0000, the constant reads 0x00FF, the count reads 0x0000, and `rfsh_req` and `cmp_irq` are low.
- R2: Address 2 holds the compare constant. A word write to it with 0x96 in bits 15:8 loads bits 7:0. On a read, bits 15:8 are zero.
- R3: Address 0 is the control/status register. A word write with 0x69 in bits 15:8 loads the interrupt enable from bit 6 and the clock select from bits 5:3. A read returns the flag in bit 7, the enable in bit 6 and the select in bits 5:3, with every other bit zero.
- R4: A write to address 0 or address 2 is ignored if it is a byte access or if its upper byte is not that register's key. A key that belongs to the other register is also rejected.
- R5: Clock-select codes 1 to 7 advance the counter once every 2, 8, 32, 128, 512, 2048 or 4096 clocks, respectively. Code 0 holds the counter.
- R6: On each tick the counter increments. If the counter equals the constant when the tick arrives, the counter instead clears to 0 and the flag is set. Matches therefore recur every (constant+1)×divisor clocks.
- R7: Each match with `rfsh_en` high produces a `rfsh_req` pulse exactly one clock wide, in the cycle after the matching edge. A match with `rfsh_en` low produces no pulse.
- R8: `cmp_irq` is high exactly while both the flag and the interrupt enable are 1.
- R9: The flag clears only on a keyed control/status write with bit 7 = 0 that follows a read of address 0 during which the flag was 1. A keyed write of 1 to bit 7 never sets the flag.
- R10: When a match and a flag-clearing write fall on the same clock edge, the flag stays set.
- R11: Manual reset clears the count, the control/status register and the flag, and leaves the constant unchanged.
- R12: Address 1 returns the current count in bits 7:0. Writes to it have no effect, whatever the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, asynchronous, active low, constant preserved |
| rfsh_en | input | 1 | Refresh enable from the refresh control register |
| bus_addr | input | 2 | Register select: 0 control/status, 1 count, 2 constant |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (arms the flag clear) |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data, key in bits 15:8 |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| rfsh_req | output | 1 | One-cycle refresh request |
| cmp_irq | output | 1 | Compare-match interrupt level |

## Verification
Register writes land on the clock edge that samples the strobe. Read data is combinational, so the bench reads back one cycle later, and because `cmp_irq` is a combinational function of registered state it can be checked at the falling edge that follows the write. A match updates the counter, the flag and `rfsh_req` together on the ticking edge. For that reason the bench does not predict the tick phase: it measures the distance between consecutive request pulses against (constant+1)×divisor and checks that the following falling edge shows the pulse low. The same-edge race is made deterministic by using divide-by-2 with constant 0, which puts matches on alternate edges. The clearing write is then placed one edge before a match in one case and on a match edge in the other.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;
   localparam int BUS_W  = 16;
   localparam int HALF_W = BUS_W / 2;
   localparam int SEL_W  = 3;
   localparam int SEL_N  = 1 << SEL_W;

   typedef enum logic [1:0] {
      RA_CTRL  = 2'd0,
      RA_COUNT = 2'd1,
      RA_CONST = 2'd2,
      RA_NONE  = 2'd3
   } reg_addr_e;

   localparam int CSR_FLAG_BIT = 7;
   localparam int CSR_IE_BIT   = 6;
   localparam int CSR_SEL_LSB  = 3;

   // log2 of the prescale divisor for a clock-select code (0 = stopped)
   function automatic int div_shift(input int code);
      if (code <= 0)      return 0;
      else if (code >= 7) return 12;
      else                return 2 * code - 1;
   endfunction
endpackage

// File: rtl/rfsh_prescale.sv
`timescale 1ns/1ps
module rfsh_prescale
   import rfsh_pkg::*;
#(
   parameter int PSC_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int MAX_SH = div_shift(SEL_N - 1);

   if (PSC_W < MAX_SH) begin : g_chk_psc
      $error("rfsh_prescale: PSC_W too narrow for the largest divisor");
   end

   logic [PSC_W-1:0] psc_q;
   logic [SEL_N-1:0] tap_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psc_q <= '0;
      else        psc_q <= psc_q + 1'b1;
   end

   assign tap_v[0] = 1'b0;
   for (genvar g = 1; g < SEL_N; g++) begin : g_tap
      localparam int SH = div_shift(g);
      assign tap_v[g] = &psc_q[SH-1:0];
   end

   assign tick = tap_v[sel];

   p_stop_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> !tick);
endmodule

// File: rtl/rfsh_count.sv
`timescale 1ns/1ps
module rfsh_count #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             rfsh_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic             match_ev,
   output logic             rfsh_req
);
   logic hit;
   logic req_q;

   assign hit      = (cnt_q == cmp_val);
   assign match_ev = tick & hit;
   assign rfsh_req = req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= match_ev & rfsh_en;
         if (match_ev)  cnt_q <= '0;
         else if (tick) cnt_q <= cnt_q + 1'b1;
      end
   end

   p_match_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev |=> (cnt_q == '0));
   p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
   p_req_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_req |=> !rfsh_req);
   p_req_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_req |-> $past(rfsh_en));
endmodule

// File: rtl/rfsh_regs.sv
`timescale 1ns/1ps
module rfsh_regs
   import rfsh_pkg::*;
#(
   parameter int          CNT_W      = 8,
   parameter logic [7:0]  KEY_CTRL   = 8'h69,
   parameter logic [7:0]  KEY_CONST  = 8'h96,
   parameter int          CONST_INIT = 255
)(
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic             bus_word,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic             match_ev,
   input  logic [CNT_W-1:0] cnt_val,
   output logic [BUS_W-1:0] bus_rdata,
   output logic [CNT_W-1:0] cmp_val,
   output logic [SEL_W-1:0] sel,
   output logic             irq
);
   localparam logic [CNT_W-1:0] CONST_RST = CONST_INIT[CNT_W-1:0];
   localparam int               PAD_W     = BUS_W - CNT_W;

   if (CNT_W > HALF_W) begin : g_chk_cnt
      $error("rfsh_regs: CNT_W must fit the lower bus byte");
   end

   logic key_hi_ctrl, key_hi_const;
   logic wr_ctrl, wr_const;
   logic ie_q, flag_q, armed_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] const_q;

   assign key_hi_ctrl  = (bus_wdata[BUS_W-1:HALF_W] == KEY_CTRL);
   assign key_hi_const = (bus_wdata[BUS_W-1:HALF_W] == KEY_CONST);
   assign wr_ctrl  = bus_wr & bus_word & (bus_addr == RA_CTRL)  & key_hi_ctrl;
   assign wr_const = bus_wr & bus_word & (bus_addr == RA_CONST) & key_hi_const;

   // constant survives manual reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        const_q <= CONST_RST;
      else if (wr_const) const_q <= bus_wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q    <= 1'b0;
         sel_q   <= '0;
         armed_q <= 1'b0;
      end else if (wr_ctrl) begin
         ie_q    <= bus_wdata[CSR_IE_BIT];
         sel_q   <= bus_wdata[CSR_SEL_LSB +: SEL_W];
         armed_q <= 1'b0;
      end else if (bus_rd && (bus_addr == RA_CTRL) && flag_q) begin
         armed_q <= 1'b1;
      end
   end

   // set has priority over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (match_ev)
         flag_q <= 1'b1;
      else if (wr_ctrl && armed_q && !bus_wdata[CSR_FLAG_BIT])
         flag_q <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CTRL: begin
            bus_rdata[CSR_FLAG_BIT]             = flag_q;
            bus_rdata[CSR_IE_BIT]               = ie_q;
            bus_rdata[CSR_SEL_LSB +: SEL_W]     = sel_q;
         end
         RA_COUNT: bus_rdata = {{PAD_W{1'b0}}, cnt_val};
         RA_CONST: bus_rdata = {{PAD_W{1'b0}}, const_q};
         default:  bus_rdata = '0;
      endcase
   end

   assign cmp_val = const_q;
   assign sel     = sel_q;
   assign irq     = flag_q & ie_q;

   p_flag_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev |=> flag_q);
   p_clear_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(armed_q));
   p_const_unkeyed_r4: assert property (@(posedge clk) disable iff (!por_n)
      (bus_wr && (bus_addr == RA_CONST) &&
       !(bus_word && (bus_wdata[BUS_W-1:HALF_W] == KEY_CONST)))
      |=> $stable(const_q));
   p_ctrl_unkeyed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == RA_CTRL) &&
       !(bus_word && (bus_wdata[BUS_W-1:HALF_W] == KEY_CTRL)) && !bus_rd)
      |=> $stable({ie_q, sel_q}));
endmodule

// File: rtl/rfsh_tmr.sv
`timescale 1ns/1ps
module rfsh_tmr
   import rfsh_pkg::*;
#(
   parameter int         CNT_W      = 8,
   parameter int         PSC_W      = 12,
   parameter logic [7:0] KEY_CTRL   = 8'h69,
   parameter logic [7:0] KEY_CONST  = 8'h96,
   parameter int         CONST_INIT = 255
)(
   input  logic        clk,
   input  logic        por_n,
   input  logic        mrst_n,
   input  logic        rfsh_en,
   input  logic [1:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic        bus_word,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        rfsh_req,
   output logic        cmp_irq
);
   if (KEY_CTRL == KEY_CONST) begin : g_chk_keys
      $error("rfsh_tmr: the two register keys must differ");
   end

   logic             rst_n;
   logic             tick;
   logic             match_ev;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] cmp_val;
   logic [CNT_W-1:0] cnt_val;

   assign rst_n = por_n & mrst_n;

   rfsh_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .tick  (tick)
   );

   rfsh_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cmp_val  (cmp_val),
      .rfsh_en  (rfsh_en),
      .cnt_q    (cnt_val),
      .match_ev (match_ev),
      .rfsh_req (rfsh_req)
   );

   rfsh_regs #(
      .CNT_W      (CNT_W),
      .KEY_CTRL   (KEY_CTRL),
      .KEY_CONST  (KEY_CONST),
      .CONST_INIT (CONST_INIT)
   ) u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_word  (bus_word),
      .bus_wdata (bus_wdata),
      .match_ev  (match_ev),
      .cnt_val   (cnt_val),
      .bus_rdata (bus_rdata),
      .cmp_val   (cmp_val),
      .sel       (sel),
      .irq       (cmp_irq)
   );
endmodule

// File: tb/rfsh_tmr_tb_top.sv
`timescale 1ns/1ps
module rfsh_tmr_tb_top;
   logic        clk = 1'b0;
   logic        por_n, mrst_n, rfsh_en;
   logic [1:0]  bus_addr;
   logic        bus_wr, bus_rd, bus_word;
   logic [15:0] bus_wdata, bus_rdata;
   logic        rfsh_req, cmp_irq;
   int          n_chk = 0;
   int          n_fail = 0;
   longint      cyc = 0;

   localparam logic [1:0] A_CTRL = 2'd0, A_COUNT = 2'd1, A_CONST = 2'd2;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rfsh_tmr dut_i (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .rfsh_en(rfsh_en),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rfsh_req(rfsh_req), .cmp_irq(cmp_irq)
   );

   function automatic longint bdiv(input int code);
      case (code)
         1: return 2;    2: return 8;    3: return 32;  4: return 128;
         5: return 512;  6: return 2048; 7: return 4096;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_now(input logic [1:0] a, input logic [15:0] d, input bit word);
      bus_addr = a; bus_wdata = d; bus_word = word; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_word = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d, input bit word);
      @(negedge clk);
      wr_now(a, d, word);
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp,
                         input string req, input string what);
      logic [15:0] v;
      rd(a, v);
      chk(v == exp, req, what, v, exp);
   endtask

   task automatic mreset();
      @(negedge clk); mrst_n = 1'b0;
      @(negedge clk); mrst_n = 1'b1;
   endtask

   task automatic wait_req(output longint t);
      while (!rfsh_req) @(negedge clk);
      t = cyc;
      @(negedge clk);
      chk(!rfsh_req, "R7", "pulse width", rfsh_req, 0);
   endtask

   task automatic run_cfg(input int code, input int n, input string req);
      longint t0, t1, t2;
      wr(A_CONST, {8'h96, 8'(n)}, 1'b1);
      mreset();
      wr(A_CTRL, {8'h69, 8'(code << 3)}, 1'b1);
      wait_req(t0);
      wait_req(t1);
      wait_req(t2);
      chk((t1 - t0) == (n + 1) * bdiv(code), req, "match interval",
          t1 - t0, (n + 1) * bdiv(code));
      chk((t2 - t1) == (n + 1) * bdiv(code), req, "match interval repeat",
          t2 - t1, (n + 1) * bdiv(code));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [15:0] c1, c2;
      int          hi_cnt;
      por_n = 1'b0; mrst_n = 1'b0; rfsh_en = 1'b0;
      bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_word = 1'b0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      por_n = 1'b1; mrst_n = 1'b1;

      // R1 power-on state
      chk(!rfsh_req && !cmp_irq, "R1", "outputs after reset", {rfsh_req, cmp_irq}, 0);
      rd_chk(A_CTRL,  16'h0000, "R1", "control after reset");
      rd_chk(A_CONST, 16'h00FF, "R1", "constant after reset");
      rd_chk(A_COUNT, 16'h0000, "R1", "count after reset");

      // R2 keyed constant write, upper byte reads zero
      wr(A_CONST, 16'h96A7, 1'b1);
      rd_chk(A_CONST, 16'h00A7, "R2", "keyed constant write");

      // R4 rejected writes
      wr(A_CONST, 16'h6911, 1'b1);
      rd_chk(A_CONST, 16'h00A7, "R4", "constant with control key");
      wr(A_CONST, 16'h9611, 1'b0);
      rd_chk(A_CONST, 16'h00A7, "R4", "constant byte write");
      wr(A_CONST, 16'h9511, 1'b1);
      rd_chk(A_CONST, 16'h00A7, "R4", "constant wrong key");
      wr(A_CTRL, 16'h9678, 1'b1);
      rd_chk(A_CTRL, 16'h0000, "R4", "control with constant key");
      wr(A_CTRL, 16'h6978, 1'b0);
      rd_chk(A_CTRL, 16'h0000, "R4", "control byte write");

      // R3 control field layout; flag not settable
      wr(A_CTRL, 16'h69FF, 1'b1);
      rd_chk(A_CTRL, 16'h0078, "R3", "control fields");
      wr(A_CTRL, 16'h6900, 1'b1);
      rd_chk(A_CTRL, 16'h0000, "R3", "control cleared");

      // R5 stopped counter, R12 count not writable
      repeat (100) @(negedge clk);
      rd_chk(A_COUNT, 16'h0000, "R5", "code 0 holds counter");
      wr(A_COUNT, 16'h6955, 1'b1);
      wr(A_COUNT, 16'h9655, 1'b1);
      rd_chk(A_COUNT, 16'h0000, "R12", "count write ignored");

      // R6/R12 count advances by one per tick (divide by 2: 10 ticks in 20 clocks)
      mreset();
      wr(A_CTRL, 16'h6908, 1'b1);
      rd(A_COUNT, c1);
      repeat (18) @(negedge clk);
      rd(A_COUNT, c2);
      chk((c2 - c1) == 16'd10, "R12", "count readback advance", c2 - c1, 10);

      // R5 divisor sweep, R6 constant sweep
      rfsh_en = 1'b1;
      for (int code = 1; code <= 7; code++) run_cfg(code, 1, "R5");
      run_cfg(1, 0,   "R6");
      run_cfg(1, 2,   "R6");
      run_cfg(1, 5,   "R6");
      run_cfg(3, 17,  "R6");
      run_cfg(1, 255, "R6");

      // R7 no request when refresh disabled; flag still set
      rfsh_en = 1'b0;
      wr(A_CONST, 16'h9603, 1'b1);
      mreset();
      wr(A_CTRL, 16'h6908, 1'b1);
      hi_cnt = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (rfsh_req) hi_cnt++;
      end
      chk(hi_cnt == 0, "R7", "request while disabled", hi_cnt, 0);
      chk(!cmp_irq, "R8", "irq with enable off", cmp_irq, 0);

      // R9 write 0 without prior read keeps flag; R8 irq follows enable
      wr(A_CTRL, 16'h6940, 1'b1);
      chk(cmp_irq, "R9", "unarmed clear ignored (irq)", cmp_irq, 1);
      rd_chk(A_CTRL, 16'h00C0, "R9", "flag still set");
      wr(A_CTRL, 16'h6940, 1'b1);
      chk(!cmp_irq, "R8", "irq drops with flag", cmp_irq, 0);
      rd_chk(A_CTRL, 16'h0040, "R9", "flag cleared after read-then-write");
      wr(A_CTRL, 16'h69C0, 1'b1);
      rd_chk(A_CTRL, 16'h0040, "R9", "writing 1 does not set flag");
      wr(A_CTRL, 16'h6900, 1'b1);
      chk(!cmp_irq, "R8", "irq with enable cleared", cmp_irq, 0);

      // R10 clear versus match on the same edge (const 0, divide by 2)
      rfsh_en = 1'b1;
      wr(A_CONST, 16'h9600, 1'b1);
      mreset();
      wr(A_CTRL, 16'h6948, 1'b1);
      repeat (4) @(negedge clk);
      rd(A_CTRL, c1);
      while (!rfsh_req) @(negedge clk);
      wr_now(A_CTRL, 16'h6948, 1'b1);   // lands on a non-match edge
      chk(!cmp_irq, "R9", "clear between matches", cmp_irq, 0);
      rd(A_CTRL, c1);
      while (!rfsh_req) @(negedge clk);
      @(negedge clk);
      wr_now(A_CTRL, 16'h6948, 1'b1);   // lands on a match edge
      chk(cmp_irq, "R10", "set wins over clear", cmp_irq, 1);
      rfsh_en = 1'b0;

      // R11 manual reset keeps constant
      wr(A_CTRL, 16'h6900, 1'b1);
      wr(A_CONST, 16'h9633, 1'b1);
      wr(A_CTRL, 16'h6940, 1'b1);
      mreset();
      rd_chk(A_CONST, 16'h0033, "R11", "constant kept");
      rd_chk(A_CTRL,  16'h0000, "R11", "control cleared");
      rd_chk(A_COUNT, 16'h0000, "R11", "count cleared");
      chk(!cmp_irq, "R11", "irq after manual reset", cmp_irq, 0);

      // R1 power-on restores constant
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      rd_chk(A_CONST, 16'h00FF, "R1", "constant after power-on");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule